// File: doc/BRIEF.md
# Four-Lane Floating-Point Min/Max Reduction

This block takes a 128-bit vector that holds four single-precision (binary32) lanes and reduces it to one scalar minimum or maximum. Lane 0 sits in bits 31:0, lane 1 in bits 63:32, lane 2 in bits 95:64 and lane 3 in bits 127:96. The reduction runs through a fixed pairwise tree of two-operand min/max nodes. The first level combines lane 0 with lane 1, and separately lane 2 with lane 3. The second level combines those two partial results. Every node uses the same operation select and the same NaN-handling mode.

Three NaN policies are available. In standard mode a quiet NaN is treated as a missing value. A signaling NaN turns into a quiet NaN at the node where it meets another operand. Because the tree order is fixed, the result in standard mode can depend on which lane holds a signaling NaN. In propagate mode any NaN poisons the result. In suppress mode every NaN, quiet or signaling, is treated as missing.

The invalid output is the OR of the invalid flags from all three nodes. It goes high whenever any lane holds a signaling NaN, and it is the only sign that the result may be unreliable. The input and the output each use a valid/ready handshake. There is one register stage per tree level, and each stage advances only when the stage after it can take data.

Top module: `fmm_reduce4`

## Requirements
- R1: For four ordinary lanes (no NaN), the result is the bit pattern of the largest lane when `in_op`=1 and of the smallest lane when `in_op`=0, with infinities ordered as the extremes.
- R2: Zeros are ordered so that -0 (0x80000000) is below +0 (0x00000000): the max of a mix of zeros is +0, and the min is -0.
- R3: In standard mode (`in_mode` 0, and also code 3), a quiet NaN (exponent all ones, fraction MSB 1) is ignored in favour of the other operand of its node. If all lanes are NaN, the result is the canonical quiet NaN 0x7FC00000. Every NaN result is exactly 0x7FC00000, whatever the payload of the NaN inputs.
- R4: In standard mode, a node that receives a signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero) outputs 0x7FC00000. The fixed order therefore gives max [sNaN,1,2,3] = 3.0 but max [1,2,3,sNaN] = 2.0.
- R5: In propagate mode (`in_mode` 1), a NaN in any lane gives 0x7FC00000, whatever its position and kind.
- R6: In suppress mode (`in_mode` 2), every NaN is ignored, and the result is 0x7FC00000 only when all four lanes are NaN.
- R7: `out_invalid` is 1 exactly when at least one lane of that vector held a signaling NaN, in every mode.
- R8: A vector accepted on a rising edge (`in_valid` and `in_ready` both high) has its result presented with `out_valid` high after the next rising edge, provided `out_ready` stays high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_invalid` hold their values.
- R10: With both stages full and `out_ready` low, `in_ready` is low and no new vector is taken. Results leave in the order their vectors were accepted.
- R11: After a synchronous reset (`rst_n` low at a rising edge), `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| in_vec | input | 128 | Four binary32 lanes, lane 0 in the low bits |
| in_op | input | 1 | 1 = maximum, 0 = minimum |
| in_mode | input | 2 | 0/3 standard, 1 propagate, 2 suppress |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Reduced scalar |
| out_invalid | output | 1 | A signaling NaN was present in the vector |

## Verification
A wrong pairing of lanes in the tree shows up at the ports only when a signaling NaN is present in standard mode. The two lane placements of R4 are there to expose it, and the result appears one cycle after acceptance. A broken zero ordering or NaN policy inside a node changes `out_result` on the very vector that triggers it. A fault in a stage's valid bit or stall logic shows up as a dropped, duplicated or changed result during the back-pressure sequence, within two or three cycles of `out_ready` falling.

// File: rtl/fmm_pkg.sv
// Package: shared widths, constants and mode codes for the min/max reduction.
// Assumes binary32 lanes; the exponent and fraction widths stay parameters.
package fmm_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int ELEM_W  = 1 + EXP_W + MAN_W;
    localparam int LANES   = 4;
    localparam int VEC_W   = ELEM_W * LANES;

    // Mode codes carried on in_mode; code 3 behaves as standard mode.
    typedef enum logic [1:0] {
        MM_STANDARD  = 2'd0,
        MM_PROPAGATE = 2'd1,
        MM_SUPPRESS  = 2'd2,
        MM_STD_ALT   = 2'd3
    } fmm_mode_e;
endpackage

// File: rtl/fmm_node.sv
// Module: fmm_node
// Two-operand floating-point min/max with a selectable NaN policy.
// Purely combinational. The clk/rst_n/chk_en pins only clock the embedded
// checks; chk_en says that the operands are live this cycle.
// Assumes IEEE-style encoding: sign, biased exponent, fraction MSB = quiet bit.
module fmm_node #(
    parameter int EW = fmm_pkg::EXP_W,
    parameter int MW = fmm_pkg::MAN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_en,
    input  logic                op_max,
    input  logic [1:0]          mode,
    input  logic [EW+MW:0]      a,
    input  logic [EW+MW:0]      b,
    output logic [EW+MW:0]      res,
    output logic                invalid
);
    localparam int W = 1 + EW + MW;
    localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
    localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};

    logic          a_nan, b_nan, a_snan, b_snan, a_gt;
    logic [W-1:0]  ka, kb, pick;

    // Classify operands and build order keys where -0 sorts below +0.
    always_comb begin
        a_nan  = (&a[W-2:MW]) && (|a[MW-1:0]);
        b_nan  = (&b[W-2:MW]) && (|b[MW-1:0]);
        a_snan = a_nan && !a[MW-1];
        b_snan = b_nan && !b[MW-1];
        ka     = a[W-1] ? ~a : (a | TOP);
        kb     = b[W-1] ? ~b : (b | TOP);
        a_gt   = ka > kb;
        pick   = (op_max == a_gt) ? a : b;
    end

    // Apply the NaN policy of the selected mode.
    always_comb begin
        invalid = a_snan || b_snan;
        case (mode)
            fmm_pkg::MM_PROPAGATE: begin
                res = (a_nan || b_nan) ? QNAN : pick;
            end
            fmm_pkg::MM_SUPPRESS: begin
                if (a_nan && b_nan) res = QNAN;
                else if (a_nan)     res = b;
                else if (b_nan)     res = a;
                else                res = pick;
            end
            default: begin
                if (a_snan || b_snan)    res = QNAN;
                else if (a_nan && b_nan) res = QNAN;
                else if (a_nan)          res = b;
                else if (b_nan)          res = a;
                else                     res = pick;
            end
        endcase
    end

    logic res_is_nan;
    assign res_is_nan = (&res[W-2:MW]) && (|res[MW-1:0]);

    // R1: with two ordinary operands the node returns one of them unchanged.
    a_r1_pick_operand: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && !a_nan && !b_nan |-> (res == a) || (res == b));

    // R5: propagate mode turns any NaN operand into the canonical NaN.
    a_r5_propagate: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && (mode == fmm_pkg::MM_PROPAGATE) && (a_nan || b_nan) |-> res == QNAN);

    // R6: suppress mode gives NaN only when both operands are NaN.
    a_r6_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && (mode == fmm_pkg::MM_SUPPRESS) && res_is_nan |-> a_nan && b_nan);

    // R3: any NaN leaving the node is the canonical pattern.
    a_r3_canonical: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && res_is_nan |-> res == QNAN);
endmodule

// File: rtl/fmm_pipe_reg.sv
// Module: fmm_pipe_reg
// One valid/ready pipeline register. It loads when the stage is empty or
// when the downstream side consumes this cycle.
// Assumes upstream holds data stable while valid is high and ready is low.
module fmm_pipe_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    logic          vld;
    logic [DW-1:0] data;

    // Stage can take data when empty or when its contents leave now.
    assign up_ready = !vld || dn_ready;
    assign dn_valid = vld;
    assign dn_data  = data;

    // Register the payload and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else if (up_ready) begin
            vld <= up_valid;
            if (up_valid) data <= up_data;
        end
    end

    // R9: a held stage keeps valid and data.
    a_r9_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !dn_ready |=> vld && $stable(data));
endmodule

// File: rtl/fmm_reduce4.sv
// Module: fmm_reduce4
// Four-lane min/max reduction: (lane0 op lane1) op (lane2 op lane3).
// Level one is registered in stage 1, level two in stage 2.
// Assumes in_vec/in_op/in_mode stay stable while in_valid is high and in_ready is low.
module fmm_reduce4 #(
    parameter int EW = fmm_pkg::EXP_W,
    parameter int MW = fmm_pkg::MAN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [4*(1+EW+MW)-1:0]    in_vec,
    input  logic                      in_op,
    input  logic [1:0]                in_mode,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [EW+MW:0]            out_result,
    output logic                      out_invalid
);
    localparam int W     = 1 + EW + MW;
    localparam int PAIRS = 2;
    localparam int S1_W  = 1 + 2 + 1 + PAIRS * W;
    localparam int S2_W  = 1 + W;

    logic [W-1:0]     l1_res [PAIRS];
    logic [PAIRS-1:0] l1_inv;
    logic             accept;

    assign accept = in_valid && in_ready;

    // Level one: one node per adjacent lane pair.
    for (genvar g = 0; g < PAIRS; g++) begin : g_lvl1
        fmm_node #(.EW(EW), .MW(MW)) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .chk_en  (accept),
            .op_max  (in_op),
            .mode    (in_mode),
            .a       (in_vec[(2*g)*W +: W]),
            .b       (in_vec[(2*g+1)*W +: W]),
            .res     (l1_res[g]),
            .invalid (l1_inv[g])
        );
    end

    logic [S1_W-1:0] s1_d, s1_q;
    logic            s1_vld, s2_up_ready;

    // Pack op, mode, partial invalid and the two partial results.
    assign s1_d = {in_op, in_mode, |l1_inv, l1_res[1], l1_res[0]};

    fmm_pipe_reg #(.DW(S1_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (s1_d),
        .dn_valid (s1_vld),
        .dn_ready (s2_up_ready),
        .dn_data  (s1_q)
    );

    logic         s1_op, s1_inv, l2_inv;
    logic [1:0]   s1_mode;
    logic [W-1:0] s1_lo, s1_hi, l2_res;

    // Unpack the stage-1 payload.
    assign {s1_op, s1_mode, s1_inv, s1_hi, s1_lo} = s1_q;

    // Level two: combine the two partial results.
    fmm_node #(.EW(EW), .MW(MW)) u_lvl2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (s1_vld && s2_up_ready),
        .op_max  (s1_op),
        .mode    (s1_mode),
        .a       (s1_lo),
        .b       (s1_hi),
        .res     (l2_res),
        .invalid (l2_inv)
    );

    logic [S2_W-1:0] s2_q;

    fmm_pipe_reg #(.DW(S2_W)) u_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (s1_vld),
        .up_ready (s2_up_ready),
        .up_data  ({s1_inv | l2_inv, l2_res}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (s2_q)
    );

    // Drive the scalar result and the combined invalid flag.
    assign {out_invalid, out_result} = s2_q;

    // R11: reset empties the output stage.
    a_r11_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R8: an accepted vector occupies stage 1 on the next cycle.
    a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> s1_vld);

    // R9: a stalled output holds its result.
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_invalid));

    // R10: both stages full under back-pressure blocks the input.
    a_r10_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld && out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_fmm_reduce4.sv
module tb_fmm_reduce4;
    localparam logic [31:0] P0 = 32'h0000_0000, N0 = 32'h8000_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, THREE = 32'h4040_0000;
    localparam logic [31:0] HALF = 32'h3F00_0000, M1 = 32'hBF80_0000, M5 = 32'hC0A0_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] QN = 32'h7FC0_0000, QN2 = 32'hFFC0_0001, SN = 32'h7F80_0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_vec = '0;
    logic         in_op = 1'b0;
    logic [1:0]   in_mode = 2'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_result;
    logic         out_invalid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    fmm_reduce4 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .in_op(in_op), .in_mode(in_mode),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Send one vector, check two-edge latency, result and flag.
    task automatic run(input logic [31:0] l0, l1, l2, l3, input logic op, input logic [1:0] md,
                       input logic [31:0] exp_res, input logic exp_inv, input string req);
        @(negedge clk);
        in_vec = {l3, l2, l1, l0}; in_op = op; in_mode = md; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R8 not yet", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R8 valid", {31'd0, out_valid}, 32'd1);
        check(out_result == exp_res, req, out_result, exp_res);
        check(out_invalid == exp_inv, {req, " R7 flag"}, {31'd0, out_invalid}, {31'd0, exp_inv});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R11 in_ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_ordinary();
        run(ONE, M5, THREE, HALF, 1'b1, 2'd0, THREE, 1'b0, "R1 max");
        run(ONE, M5, THREE, HALF, 1'b0, 2'd0, M5, 1'b0, "R1 min");
        run(NINF, M1, M5, PINF, 1'b1, 2'd1, PINF, 1'b0, "R1 max inf");
        run(NINF, M1, M5, PINF, 1'b0, 2'd2, NINF, 1'b0, "R1 min inf");
    endtask

    task automatic t_zero();
        run(P0, N0, N0, N0, 1'b1, 2'd0, P0, 1'b0, "R2 max zeros");
        run(P0, N0, P0, P0, 1'b0, 2'd0, N0, 1'b0, "R2 min zeros");
        run(N0, P0, N0, N0, 1'b0, 2'd2, N0, 1'b0, "R2 min lane1");
    endtask

    task automatic t_std_quiet();
        run(QN, ONE, QN2, TWO, 1'b1, 2'd0, TWO, 1'b0, "R3 quiet skipped");
        run(QN2, QN2, QN, QN, 1'b1, 2'd0, QN, 1'b0, "R3 all nan canonical");
        run(QN, ONE, TWO, QN, 1'b1, 2'd3, TWO, 1'b0, "R3 code3");
    endtask

    task automatic t_std_signal();
        run(SN, ONE, TWO, THREE, 1'b1, 2'd0, THREE, 1'b1, "R4 snan lane0");
        run(ONE, TWO, THREE, SN, 1'b1, 2'd0, TWO, 1'b1, "R4 snan lane3");
        run(ONE, SN, M1, TWO, 1'b0, 2'd0, M1, 1'b1, "R4 snan min");
    endtask

    task automatic t_propagate();
        run(ONE, TWO, QN, THREE, 1'b1, 2'd1, QN, 1'b0, "R5 quiet lane2");
        run(QN2, ONE, TWO, THREE, 1'b0, 2'd1, QN, 1'b0, "R5 payload lane0");
        run(ONE, TWO, THREE, SN, 1'b1, 2'd1, QN, 1'b1, "R5 snan lane3");
    endtask

    task automatic t_suppress();
        run(SN, ONE, TWO, THREE, 1'b1, 2'd2, THREE, 1'b1, "R6 snan lane0");
        run(ONE, TWO, THREE, SN, 1'b1, 2'd2, THREE, 1'b1, "R6 snan lane3");
        run(QN, SN, QN2, QN, 1'b1, 2'd2, QN, 1'b1, "R6 all nan");
        run(QN, QN, QN, M1, 1'b0, 2'd2, M1, 1'b0, "R6 one number");
    endtask

    // Stall the output with both stages full, then drain in order.
    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_vec = {M5, ONE, M1, HALF}; in_op = 1'b1; in_mode = 2'd0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vec = {TWO, M1, M1, M1}; in_op = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vec = {THREE, THREE, THREE, THREE}; in_op = 1'b0;
        check(out_valid == 1'b1 && out_result == ONE, "R10 first out", out_result, ONE);
        check(in_ready == 1'b0, "R10 in_ready low", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1 && out_result == ONE, "R9 held", out_result, ONE);
        check(in_ready == 1'b0, "R10 still blocked", {31'd0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && out_result == TWO, "R10 second out", out_result, TWO);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1 && out_result == THREE, "R10 third out", out_result, THREE);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 drained", {31'd0, out_valid}, 32'd0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ordinary();
        t_zero();
        t_std_quiet();
        t_std_signal();
        t_propagate();
        t_suppress();
        t_backpressure();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule